// File: doc/BRIEF.md
# Boot Record Integrity Checker

This block watches a 16 KiB boot record image as it streams past, one byte on each cycle where `valid_i` is high. It decides whether the image may be executed. It keeps no copy of the image. Instead it folds the image into a running 16-bit word sum, keeps a flag for the signature word, and keeps the stored checksum word. When the last byte has gone by, it reports a verdict, a two-bit reason code and a boot-or-recovery decision.

A transfer begins with a one-cycle `start_i` pulse. The first byte accepted after that pulse is offset 0x0000. Byte pairs form little-endian words: the even offset gives the low byte and the odd offset gives the high byte. The control path is a five-state machine:
- `ST_IDLE`: waiting, holding the last result.
- `ST_SUM`: offsets 0x0000 to 0x3FBD, which are summed.
- `ST_CSUM`: offsets 0x3FBE and 0x3FBF, which hold the stored checksum.
- `ST_TAIL`: offsets 0x3FC0 to 0x3FFF, which are consumed and ignored.
- `ST_DONE`: the single reporting cycle.

The transitions are:
- *t_start*: any state to `ST_SUM` on `start_i`.
- *t_sum_end*: `ST_SUM` to `ST_CSUM` after byte 0x3FBD.
- *t_csum_end*: `ST_CSUM` to `ST_TAIL` after byte 0x3FBF.
- *t_last*: `ST_TAIL` to `ST_DONE` after byte 0x3FFF.
- *t_report*: `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `bootrec_check`

## Requirements
- R1: After reset, `done_o`, `pass_o`, `sig_err_o`, `sum_err_o` and `boot_o` are 0 and `reason_o` is 2'b00.
- R2: A `start_i` pulse clears the result flags and the byte offset. A byte presented in the same cycle as `start_i` is not accepted. Bytes presented before the first `start_i` are not accepted.
- R3: The little-endian word at offsets 0x3FBC (low byte) and 0x3FBD (high byte) must equal 0x55AA. Otherwise the image is rejected with `sig_err_o`=1 and `reason_o`=2'b01, whatever the checksum is.
- R4: With a good signature, the modulo-65536 sum of all little-endian words from 0x0000 through 0x3FBD is compared with the word at 0x3FBE (low byte) and 0x3FBF (high byte). The signature word is included in the sum. A mismatch gives `sum_err_o`=1 and `reason_o`=2'b10.
- R5: On pass, `pass_o`=1, `reason_o`=2'b00 and `boot_o`=1, which selects execution from address 0x0000. On any failure, `boot_o`=0, which selects the recovery path.
- R6: `done_o` is high for exactly one cycle: the cycle after the byte at offset 0x3FFF is accepted. In that cycle exactly one of `pass_o`, `sig_err_o` and `sum_err_o` is 1.
- R7: `pass_o`, `sig_err_o` and `sum_err_o` hold their values from the reporting cycle until the next `start_i`.
- R8: The contents of bytes 0x3FC0 to 0x3FFF have no effect on the result.
- R9: A `start_i` pulse during a partial image discards that image. No `done_o` is produced for it, and the next image is checked from offset 0x0000.
- R10: Cycles with `valid_i` low do not advance the offset, so gaps anywhere in the stream do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a new image |
| valid_i | input | 1 | `data_i` carries the next image byte |
| data_i | input | 8 | Image byte |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| pass_o | output | 1 | Image passed both tests |
| sig_err_o | output | 1 | Signature word was wrong |
| sum_err_o | output | 1 | Checksum mismatch with a good signature |
| reason_o | output | 2 | 00 pass, 01 bad signature, 10 bad checksum |
| boot_o | output | 1 | 1 = boot from 0x0000, 0 = recovery path |

## Verification
The hardest case to reach is a checksum mismatch with a correct signature that comes from a single corrupted body byte. Random images almost never produce this by chance. The bench therefore builds each image from a seeded hash and computes the stored checksum from the clean image. It then flips one byte at a random body offset during transmission. The word sum also has to wrap many times. An all-0xFF body forces thousands of carries out of bit 15, and the bench adds random single-cycle gaps and an abandoned partial image, so the offset counter is exercised under pauses and restarts.

// File: rtl/bootrec_pkg.sv
package bootrec_pkg;

    localparam int unsigned BRC_IMG_BYTES = 16384;
    localparam int unsigned BRC_SIG_OFS   = 'h3FBC;
    localparam int unsigned BRC_CSUM_OFS  = 'h3FBE;
    localparam int unsigned BRC_SIG_WORD  = 'h55AA;
    localparam int unsigned BRC_BYTE_W    = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SUM  = 3'd1,
        ST_CSUM = 3'd2,
        ST_TAIL = 3'd3,
        ST_DONE = 3'd4
    } brc_state_e;

    typedef enum logic [1:0] {
        RSN_OK  = 2'b00,
        RSN_SIG = 2'b01,
        RSN_SUM = 2'b10
    } brc_reason_e;

    typedef struct packed {
        logic pass;
        logic sig_err;
        logic sum_err;
    } brc_verdict_t;

endpackage

// File: rtl/brc_stream.sv
// Byte offset tracking and little-endian word pairing.
module brc_stream #(
    parameter int unsigned OFS_W  = 14,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              accept_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [OFS_W-1:0]  ofs_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_v_o
);

    logic [OFS_W-1:0]  ofs_q;
    logic [BYTE_W-1:0] lo_q;

    // offset of the byte currently presented
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '0;
        end else if (clear_i) begin
            ofs_q <= '0;
        end else if (accept_i) begin
            ofs_q <= ofs_q + 1'b1;
        end
    end

    // even offsets deliver the low half of a word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (clear_i) begin
            lo_q <= '0;
        end else if (accept_i && !ofs_q[0]) begin
            lo_q <= data_i;
        end
    end

    assign ofs_o    = ofs_q;
    assign word_o   = {data_i, lo_q};
    assign word_v_o = accept_i && ofs_q[0];

endmodule

// File: rtl/brc_accum.sv
// Running word sum, signature test and stored checksum capture.
module brc_accum #(
    parameter int unsigned OFS_W    = 14,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned SIG_OFS  = 'h3FBC,
    parameter int unsigned CSUM_OFS = 'h3FBE,
    parameter int unsigned SIG_WORD = 'h55AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              word_v_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [WORD_W-1:0] sum_o,
    output logic              sig_ok_o,
    output logic [WORD_W-1:0] csum_o
);

    localparam logic [OFS_W-1:0]  SIG_HI_L  = OFS_W'(SIG_OFS + 1);
    localparam logic [OFS_W-1:0]  CSUM_HI_L = OFS_W'(CSUM_OFS + 1);
    localparam logic [WORD_W-1:0] SIG_VAL_L = WORD_W'(SIG_WORD);

    logic              in_range;
    logic              at_sig;
    logic              at_csum;
    logic [WORD_W-1:0] sum_q;
    logic              sig_ok_q;
    logic [WORD_W-1:0] csum_q;

    // the summed range ends with the signature word
    assign in_range = (ofs_i <= SIG_HI_L);
    assign at_sig   = (ofs_i == SIG_HI_L);
    assign at_csum  = (ofs_i == CSUM_HI_L);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clear_i) begin
            sum_q <= '0;
        end else if (word_v_i && in_range) begin
            sum_q <= sum_q + word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_ok_q <= 1'b0;
        end else if (clear_i) begin
            sig_ok_q <= 1'b0;
        end else if (word_v_i && at_sig) begin
            sig_ok_q <= (word_i == SIG_VAL_L);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csum_q <= '0;
        end else if (clear_i) begin
            csum_q <= '0;
        end else if (word_v_i && at_csum) begin
            csum_q <= word_i;
        end
    end

    assign sum_o    = sum_q;
    assign sig_ok_o = sig_ok_q;
    assign csum_o   = csum_q;

endmodule

// File: rtl/brc_ctrl.sv
// Sequencing state machine and verdict registers.
module brc_ctrl
    import bootrec_pkg::*;
#(
    parameter int unsigned OFS_W     = 14,
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned IMG_BYTES = 16384,
    parameter int unsigned SIG_OFS   = 'h3FBC,
    parameter int unsigned CSUM_OFS  = 'h3FBE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic              sig_ok_i,
    input  logic [WORD_W-1:0] sum_i,
    input  logic [WORD_W-1:0] csum_i,
    output logic              accept_o,
    output logic              clear_o,
    output logic              done_o,
    output brc_verdict_t      verdict_o,
    output logic [1:0]        reason_o
);

    localparam logic [OFS_W-1:0] SUM_END_L  = OFS_W'(SIG_OFS + 1);
    localparam logic [OFS_W-1:0] CSUM_END_L = OFS_W'(CSUM_OFS + 1);
    localparam logic [OFS_W-1:0] LAST_L     = OFS_W'(IMG_BYTES - 1);

    brc_state_e   state_q, state_d;
    logic         receiving;
    logic         last_beat;
    logic         done_q;
    brc_verdict_t verdict_q;

    assign receiving = (state_q == ST_SUM) || (state_q == ST_CSUM) ||
                       (state_q == ST_TAIL);
    assign accept_o  = valid_i && !start_i && receiving;
    assign clear_o   = start_i;
    assign last_beat = accept_o && (state_q == ST_TAIL) && (ofs_i == LAST_L);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_SUM;                                   // t_start
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_SUM: begin
                    if (accept_o && ofs_i == SUM_END_L) begin
                        state_d = ST_CSUM;                      // t_sum_end
                    end
                end
                ST_CSUM: begin
                    if (accept_o && ofs_i == CSUM_END_L) begin
                        state_d = ST_TAIL;                      // t_csum_end
                    end
                end
                ST_TAIL: begin
                    if (last_beat) begin
                        state_d = ST_DONE;                      // t_last
                    end
                end
                ST_DONE: state_d = ST_IDLE;                     // t_report
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // output registers: verdict is decided on the final byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            verdict_q <= '0;
        end else if (start_i) begin
            done_q    <= 1'b0;
            verdict_q <= '0;
        end else if (last_beat) begin
            done_q            <= 1'b1;
            verdict_q.pass    <= sig_ok_i && (sum_i == csum_i);
            verdict_q.sig_err <= !sig_ok_i;
            verdict_q.sum_err <= sig_ok_i && (sum_i != csum_i);
        end else begin
            done_q    <= 1'b0;
        end
    end

    // reason code, signature failure ranks first
    always_comb begin
        if (verdict_q.sig_err) begin
            reason_o = RSN_SIG;
        end else if (verdict_q.sum_err) begin
            reason_o = RSN_SUM;
        end else begin
            reason_o = RSN_OK;
        end
    end

    assign done_o    = done_q;
    assign verdict_o = verdict_q;

endmodule

// File: rtl/bootrec_check.sv
module bootrec_check
    import bootrec_pkg::*;
#(
    parameter int unsigned IMG_BYTES = BRC_IMG_BYTES,
    parameter int unsigned SIG_OFS   = BRC_SIG_OFS,
    parameter int unsigned CSUM_OFS  = BRC_CSUM_OFS,
    parameter int unsigned SIG_WORD  = BRC_SIG_WORD,
    parameter int unsigned BYTE_W    = BRC_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              done_o,
    output logic              pass_o,
    output logic              sig_err_o,
    output logic              sum_err_o,
    output logic [1:0]        reason_o,
    output logic              boot_o
);

    localparam int unsigned OFS_W  = $clog2(IMG_BYTES);
    localparam int unsigned WORD_W = 2 * BYTE_W;

    logic              accept;
    logic              clear;
    logic [OFS_W-1:0]  ofs;
    logic [WORD_W-1:0] word;
    logic              word_v;
    logic [WORD_W-1:0] sum;
    logic [WORD_W-1:0] csum;
    logic              sig_ok;
    brc_verdict_t      verdict;

    brc_stream #(
        .OFS_W  (OFS_W),
        .BYTE_W (BYTE_W)
    ) u_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .accept_i (accept),
        .data_i   (data_i),
        .ofs_o    (ofs),
        .word_o   (word),
        .word_v_o (word_v)
    );

    brc_accum #(
        .OFS_W    (OFS_W),
        .WORD_W   (WORD_W),
        .SIG_OFS  (SIG_OFS),
        .CSUM_OFS (CSUM_OFS),
        .SIG_WORD (SIG_WORD)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clear),
        .word_v_i (word_v),
        .word_i   (word),
        .ofs_i    (ofs),
        .sum_o    (sum),
        .sig_ok_o (sig_ok),
        .csum_o   (csum)
    );

    brc_ctrl #(
        .OFS_W     (OFS_W),
        .WORD_W    (WORD_W),
        .IMG_BYTES (IMG_BYTES),
        .SIG_OFS   (SIG_OFS),
        .CSUM_OFS  (CSUM_OFS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .valid_i   (valid_i),
        .ofs_i     (ofs),
        .sig_ok_i  (sig_ok),
        .sum_i     (sum),
        .csum_i    (csum),
        .accept_o  (accept),
        .clear_o   (clear),
        .done_o    (done_o),
        .verdict_o (verdict),
        .reason_o  (reason_o)
    );

    assign pass_o    = verdict.pass;
    assign sig_err_o = verdict.sig_err;
    assign sum_err_o = verdict.sum_err;
    assign boot_o    = verdict.pass;

endmodule

// File: rtl/bootrec_check_sva.sv
module bootrec_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       done_o,
    input logic       pass_o,
    input logic       sig_err_o,
    input logic       sum_err_o,
    input logic [1:0] reason_o,
    input logic       boot_o
);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $onehot({pass_o, sig_err_o, sum_err_o}));

    // R6
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pass_o, sig_err_o, sum_err_o}));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !pass_o && !sig_err_o && !sum_err_o));

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable({pass_o, sig_err_o, sum_err_o}) || $rose(done_o)));

    // R3
    sig_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && sig_err_o) |-> (reason_o == 2'b01));

    // R5
    boot_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(boot_o) |-> done_o);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!done_o && !pass_o && !boot_o));

endmodule

bind bootrec_check bootrec_check_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .sig_err_o (sig_err_o),
    .sum_err_o (sum_err_o),
    .reason_o  (reason_o),
    .boot_o    (boot_o)
);

// File: tb/bootrec_check_tb.sv
module bootrec_check_tb;

    localparam int IMG   = 16384;
    localparam int SIGO  = 'h3FBC;
    localparam int CSO   = 'h3FBE;
    localparam int WDOG  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       valid_i = 1'b0;
    logic [7:0] data_i = 8'h00;
    logic       done_o, pass_o, sig_err_o, sum_err_o, boot_o;
    logic [1:0] reason_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    // image description
    int unsigned cfg_seed;
    int unsigned cfg_tail_seed;
    bit          cfg_fill_ff;
    logic [15:0] cfg_sig;
    logic [15:0] cfg_csum_xor;
    int          cfg_flip;

    always #2.5 clk = ~clk;

    bootrec_check u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .done_o(done_o), .pass_o(pass_o),
        .sig_err_o(sig_err_o), .sum_err_o(sum_err_o),
        .reason_o(reason_o), .boot_o(boot_o)
    );

    function automatic logic [7:0] hash8(int unsigned s, int ofs);
        logic [31:0] h;
        h = s ^ (ofs * 32'h9E3779B1);
        h = h ^ (h >> 15);
        h = h * 32'h2C1B3C6D;
        h = h ^ (h >> 12);
        return h[7:0];
    endfunction

    // byte of the clean image outside the checksum word
    function automatic logic [7:0] body_byte(int ofs);
        if (ofs == SIGO)     return cfg_sig[7:0];
        if (ofs == SIGO + 1) return cfg_sig[15:8];
        if (ofs >= 'h3FC0)   return hash8(cfg_tail_seed, ofs);
        if (cfg_fill_ff)     return 8'hFF;
        return hash8(cfg_seed, ofs);
    endfunction

    function automatic logic [15:0] clean_sum();
        logic [15:0] s = 16'h0;
        for (int w = 0; w <= SIGO; w += 2) s = s + {body_byte(w + 1), body_byte(w)};
        return s;
    endfunction

    function automatic logic [7:0] sent_byte(int ofs, logic [15:0] stored);
        logic [7:0] b;
        if (ofs == CSO)          b = stored[7:0];
        else if (ofs == CSO + 1) b = stored[15:8];
        else                     b = body_byte(ofs);
        if (ofs == cfg_flip) b = b ^ 8'h10;
        return b;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        valid_i = 1'($urandom % 2);   // R2: byte beside start is dropped
        data_i  = 8'($urandom);
        @(negedge clk);
        start_i = 1'b0;
        valid_i = 1'b0;
    endtask

    task automatic send_bytes(int count, logic [15:0] stored);
        for (int o = 0; o < count; o++) begin
            if ($urandom % 32 == 0) begin         // R10: idle gap
                @(negedge clk);
                valid_i = 1'b0;
                data_i  = 8'($urandom);
            end
            @(negedge clk);
            valid_i = 1'b1;
            data_i  = sent_byte(o, stored);
        end
    endtask

    task automatic run_image(string name);
        logic [15:0] stored, actual;
        bit          sig_ok, exp_pass, exp_serr, exp_cerr;
        logic [1:0]  exp_rsn;
        stored = clean_sum() ^ cfg_csum_xor;
        actual = 16'h0;
        for (int w = 0; w <= SIGO; w += 2)
            actual = actual + {sent_byte(w + 1, stored), sent_byte(w, stored)};
        sig_ok   = (cfg_sig == 16'h55AA);
        exp_serr = !sig_ok;
        exp_cerr = sig_ok && (actual != stored);
        exp_pass = sig_ok && (actual == stored);
        exp_rsn  = exp_serr ? 2'b01 : (exp_cerr ? 2'b10 : 2'b00);
        pulse_start();
        send_bytes(IMG, stored);
        @(negedge clk);
        valid_i = 1'b0;
        check({name, " R6 done"},     done_o, 1);
        check({name, " R3 sig_err"},  sig_err_o, exp_serr);
        check({name, " R4 sum_err"},  sum_err_o, exp_cerr);
        check({name, " R5 pass"},     pass_o, exp_pass);
        check({name, " R5 reason"},   reason_o, exp_rsn);
        check({name, " R5 boot"},     boot_o, exp_pass);
        repeat (3) @(negedge clk);
        check({name, " R6 done low"}, done_o, 0);
        check({name, " R7 hold"},     {pass_o, sig_err_o, sum_err_o},
              {exp_pass, exp_serr, exp_cerr});
    endtask

    task automatic set_cfg(int unsigned seed, int unsigned tseed, bit ff,
                           logic [15:0] sig, logic [15:0] cx, int flip);
        cfg_seed = seed; cfg_tail_seed = tseed; cfg_fill_ff = ff;
        cfg_sig = sig; cfg_csum_xor = cx; cfg_flip = flip;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 done",   done_o, 0);
        check("R1 flags",  {pass_o, sig_err_o, sum_err_o}, 0);
        check("R1 reason", reason_o, 0);
        check("R1 boot",   boot_o, 0);

        // R2: bytes before any start are ignored
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            valid_i = 1'b1;
            data_i  = 8'($urandom);
        end
        @(negedge clk);
        valid_i = 1'b0;
        check("R2 idle bytes done", done_o, 0);

        set_cfg(11, 500, 0, 16'h55AA, 16'h0, -1);
        run_image("good");
        // R8: same body, different tail
        set_cfg(11, 777, 0, 16'h55AA, 16'h0, -1);
        run_image("tail R8");
        // R3: bad signature, correct checksum for it
        set_cfg(23, 5, 0, 16'hAA55, 16'h0, -1);
        run_image("badsig");
        // R3 priority: bad signature and bad checksum
        set_cfg(31, 6, 0, 16'h55AB, 16'h1234, -1);
        run_image("both");
        // R4: one flipped body byte
        set_cfg(47, 8, 0, 16'h55AA, 16'h0, int'($urandom % SIGO));
        run_image("flip R4");
        // R4: wrapping sum with all-0xFF body
        set_cfg(0, 9, 1, 16'h55AA, 16'h0, -1);
        run_image("ovf R4");

        // R9: partial image abandoned by a restart
        set_cfg(55, 3, 0, 16'h55AA, 16'h0, -1);
        pulse_start();
        send_bytes(3000, 16'h0);
        @(negedge clk);
        valid_i = 1'b0;
        check("R9 no done on partial", done_o, 0);
        check("R9 flags cleared", {pass_o, sig_err_o, sum_err_o}, 0);
        run_image("restart R9");

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule